// File: doc/BRIEF.md
# Prioritized Restart Interrupt Controller

This block gathers the interrupt requests of a small 8-bit processor core and picks one of them at each instruction boundary. Five sources feed it. The first is a non-maskable emergency input. Three restart lines each have their own mask bit and their own fixed vector. The last is a general request whose vector comes from external logic through an acknowledge cycle. The core raises a sample strobe on the next-to-last clock of each instruction. On that edge the controller takes the highest-priority eligible source. In the following cycle it pulses a hold flag, which stops the program counter from incrementing, and it presents the restart vector or, for the general request, pulses an acknowledge.

A global enable gates every source except the non-maskable one. Software sets it and clears it with command strobes. The controller clears it by itself whenever it accepts a maskable source. The high restart line is edge-triggered through a latch. The middle and low restart lines are level-sensitive. A mask command updates the three mask bits only when its write-qualifier bit is set. The same command can also discard a latched high-line edge.

Top module: `irc_ctrl`

## Requirements
- R1: After reset, `irq_pend_o`, `pc_hold_o` and `ext_ack_o` are 0, `vec_o` is 0x0000, the global enable is clear, all three restart masks are set and the high-line latch is empty.
- R2: When several sources are eligible at one sample, the winner is chosen in this order, highest first: non-maskable, high restart, middle restart, low restart, general request.
- R3: The non-maskable source is accepted whatever the mask bits and the global enable are, and accepting it leaves the global enable unchanged.
- R4: A source is accepted only on a clock edge where `smp_stb_i` is 1. On the next cycle `pc_hold_o` is 1 for exactly one cycle. With no strobe, `pc_hold_o` stays 0.
- R5: The global enable is set by `ien_set_i` and cleared by `ien_clr_i`. If both are high, clear wins. It is cleared on the edge that accepts any maskable source.
- R6: Accepting the general request pulses `ext_ack_o` together with `pc_hold_o` for one cycle and sets `vec_o` to 0x0000. The general request has no mask bit.
- R7: Accepting a restart or the non-maskable source sets `vec_o` to the source's vector: 0x0024 for non-maskable, 0x003C for high, 0x0034 for middle and 0x002C for low. `ext_ack_o` stays 0.
- R8: A rising edge on `rq_hi_i` is latched even if the line is masked or falls again. The latch is cleared when that source is accepted, or by a command write with `cmd_i[4]`=1.
- R9: The middle and low restart lines are level-sensitive. A line that is low at the sample edge is not accepted.
- R10: A command write (`cmd_we_i`=1) loads `cmd_i[2:0]` into the masks only when `cmd_i[3]`=1. Bit 2 masks the high line, bit 1 the middle line and bit 0 the low line, and a 1 masks.
- R11: The non-maskable input becomes eligible only after a rising edge, and only while it stays high. After it has been accepted, a level held high is not accepted again until the input falls and rises.
- R12: `irq_pend_o` is 1 in the same cycle that any source is eligible, whether or not the strobe is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_i | input | 1 | Non-maskable request |
| rq_hi_i | input | 1 | High restart request, edge-triggered |
| rq_mid_i | input | 1 | Middle restart request, level |
| rq_lo_i | input | 1 | Low restart request, level |
| ext_req_i | input | 1 | General request, externally vectored |
| ien_set_i | input | 1 | Set the global enable |
| ien_clr_i | input | 1 | Clear the global enable |
| cmd_we_i | input | 1 | Mask command write strobe |
| cmd_i | input | 5 | [4] discard high latch, [3] mask write qualifier, [2:0] masks |
| smp_stb_i | input | 1 | Instruction-boundary sample strobe |
| irq_pend_o | output | 1 | Some source is eligible now |
| vec_o | output | 16 | Vector of the last accepted source |
| ext_ack_o | output | 1 | Acknowledge pulse for the general request |
| pc_hold_o | output | 1 | Inhibit program-counter increment, one cycle |

## Verification
The case that is hardest to reach from the ports is a stack of simultaneously pending sources being drained one at a time. Each acceptance of a maskable source clears the global enable, so the bench has to re-enable between samples to see each lower source win in turn. The high-line edge must also be latched and then removed from the pin before the first sample, which shows that the latch rather than the level carries it. The non-maskable re-arm case is just as indirect. The input stays high across one acceptance and a further sample, which must yield nothing. A short pulse that falls before its sample must also produce nothing.

// File: rtl/irc_pkg.sv
package irc_pkg;
  localparam int NSRC  = 5;
  localparam int NRST  = 3;
  localparam int VEC_W = 16;

  // priority index: lower wins
  typedef enum logic [2:0] {
    SRC_NMI = 3'd0,
    SRC_HI  = 3'd1,
    SRC_MID = 3'd2,
    SRC_LO  = 3'd3,
    SRC_EXT = 3'd4
  } src_e;

  typedef struct packed {
    logic            clr_hi;
    logic            mask_we;
    logic [NRST-1:0] mask;
  } mask_cmd_t;
endpackage

// File: rtl/irc_nmi_qual.sv
module irc_nmi_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_in,
  input  logic taken,
  output logic elig_o
);
  logic prev_q, prev_d;
  logic armed_q, armed_d;

  always_comb begin
    prev_d  = nmi_in;
    armed_d = armed_q;
    if (!nmi_in || taken) armed_d = 1'b0;
    if (nmi_in && !prev_q) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      armed_q <= armed_d;
    end
  end

  assign elig_o = armed_q & nmi_in;

  // R11
  nmi_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> !elig_o);
endmodule

// File: rtl/irc_edge_latch.sv
module irc_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_in,
  input  logic clr,
  output logic pend_o
);
  logic prev_q, pend_q, pend_d, rise;

  assign rise = lvl_in & ~prev_q;

  always_comb begin
    pend_d = pend_q;
    if (clr)  pend_d = 1'b0;
    if (rise) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= lvl_in;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R8
  hi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !rise) |=> !pend_o);
endmodule

// File: rtl/irc_arbiter.sv
module irc_arbiter #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  always_comb begin
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) grant = N'(1) << i;
    end
  end

  assign any = |req;
endmodule

// File: rtl/irc_ctrl.sv
module irc_ctrl
  import irc_pkg::*;
#(
  parameter logic [VEC_W-1:0] NMI_VEC = 16'h0024,
  parameter logic [VEC_W-1:0] HI_VEC  = 16'h003C,
  parameter logic [VEC_W-1:0] MID_VEC = 16'h0034,
  parameter logic [VEC_W-1:0] LO_VEC  = 16'h002C,
  parameter int               SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_i,
  input  logic             rq_hi_i,
  input  logic             rq_mid_i,
  input  logic             rq_lo_i,
  input  logic             ext_req_i,
  input  logic             ien_set_i,
  input  logic             ien_clr_i,
  input  logic             cmd_we_i,
  input  logic [4:0]       cmd_i,
  input  logic             smp_stb_i,
  output logic             irq_pend_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             ext_ack_o,
  output logic             pc_hold_o
);
  // reset: asserted at once, released on a clock edge
  logic [SYNC_STAGES-1:0] sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  logic rst_s_n;
  assign rst_s_n = sync_q[SYNC_STAGES-1];

  mask_cmd_t cmd;
  assign cmd = mask_cmd_t'(cmd_i);

  logic [NRST-1:0] mask_q, mask_d;
  logic            ien_q, ien_d;
  logic [NRST-1:0] rs_raw, rs_elig;
  logic [NSRC-1:0] req, grant;
  logic            any, accept;
  logic            nmi_elig, hi_pend, hi_clr;
  logic [VEC_W-1:0] vec_sel;
  logic             pc_hold_q, ack_q;
  logic [VEC_W-1:0] vec_q, vec_d;

  irc_nmi_qual u_nmi (
    .clk(clk), .rst_n(rst_s_n), .nmi_in(nmi_i),
    .taken(accept & grant[SRC_NMI]), .elig_o(nmi_elig)
  );

  assign hi_clr = (accept & grant[SRC_HI]) | (cmd_we_i & cmd.clr_hi);

  irc_edge_latch u_hi (
    .clk(clk), .rst_n(rst_s_n), .lvl_in(rq_hi_i),
    .clr(hi_clr), .pend_o(hi_pend)
  );

  // mask bit i guards restart line i: 2 high, 1 middle, 0 low
  assign rs_raw = {hi_pend, rq_mid_i, rq_lo_i};
  for (genvar g = 0; g < NRST; g++) begin : g_rs
    assign rs_elig[g] = rs_raw[g] & ~mask_q[g] & ien_q;
    assign req[SRC_LO - g] = rs_elig[g];
  end
  assign req[SRC_NMI] = nmi_elig;
  assign req[SRC_EXT] = ext_req_i & ien_q;

  irc_arbiter #(.N(NSRC)) u_arb (.req(req), .grant(grant), .any(any));

  assign accept = smp_stb_i & any;

  always_comb begin
    unique case (1'b1)
      grant[SRC_NMI]: vec_sel = NMI_VEC;
      grant[SRC_HI]:  vec_sel = HI_VEC;
      grant[SRC_MID]: vec_sel = MID_VEC;
      grant[SRC_LO]:  vec_sel = LO_VEC;
      default:        vec_sel = '0;
    endcase
  end

  always_comb begin
    ien_d = ien_q;
    if (ien_set_i) ien_d = 1'b1;
    if (ien_clr_i) ien_d = 1'b0;
    if (accept && !grant[SRC_NMI]) ien_d = 1'b0;
    mask_d = (cmd_we_i && cmd.mask_we) ? cmd.mask : mask_q;
    vec_d  = accept ? vec_sel : vec_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ien_q     <= 1'b0;
      mask_q    <= '1;
      vec_q     <= '0;
      pc_hold_q <= 1'b0;
      ack_q     <= 1'b0;
    end else begin
      ien_q     <= ien_d;
      mask_q    <= mask_d;
      vec_q     <= vec_d;
      pc_hold_q <= accept;
      ack_q     <= accept & grant[SRC_EXT];
    end
  end

  assign irq_pend_o = any;
  assign vec_o      = vec_q;
  assign ext_ack_o  = ack_q;
  assign pc_hold_o  = pc_hold_q;

  // R6
  ack_with_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    ext_ack_o |-> pc_hold_o);
  // R5
  ien_drop_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (accept && !grant[SRC_NMI]) |=> !ien_q);
  // R3
  nmi_first_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (smp_stb_i && nmi_elig) |=> (pc_hold_o && vec_o == NMI_VEC && !ext_ack_o));
  // R4
  no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !smp_stb_i |=> !pc_hold_o);
  // R2
  hi_over_mid_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (smp_stb_i && !nmi_elig && rs_elig[2] && rs_elig[1]) |=> vec_o == HI_VEC);
endmodule

// File: tb/irc_ctrl_tb.sv
module irc_ctrl_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic nmi_i, rq_hi_i, rq_mid_i, rq_lo_i, ext_req_i;
  logic ien_set_i, ien_clr_i, cmd_we_i, smp_stb_i;
  logic [4:0]  cmd_i;
  logic        irq_pend_o, ext_ack_o, pc_hold_o;
  logic [15:0] vec_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  irc_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .rq_hi_i(rq_hi_i),
    .rq_mid_i(rq_mid_i), .rq_lo_i(rq_lo_i), .ext_req_i(ext_req_i),
    .ien_set_i(ien_set_i), .ien_clr_i(ien_clr_i), .cmd_we_i(cmd_we_i),
    .cmd_i(cmd_i), .smp_stb_i(smp_stb_i), .irq_pend_o(irq_pend_o),
    .vec_o(vec_o), .ext_ack_o(ext_ack_o), .pc_hold_o(pc_hold_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic sample();
    smp_stb_i = 1'b1; step(); smp_stb_i = 1'b0;
  endtask

  task automatic ien_on();
    ien_set_i = 1'b1; step(); ien_set_i = 1'b0;
  endtask

  task automatic ien_off();
    ien_clr_i = 1'b1; step(); ien_clr_i = 1'b0;
  endtask

  task automatic write_cmd(input logic [4:0] c);
    cmd_i = c; cmd_we_i = 1'b1; step(); cmd_we_i = 1'b0; cmd_i = '0;
  endtask

  task automatic t_reset();
    check("R1 pend", irq_pend_o, 0);
    check("R1 hold", pc_hold_o, 0);
    check("R1 ack", ext_ack_o, 0);
    check("R1 vec", vec_o, 0);
    ext_req_i = 1'b1; rq_mid_i = 1'b1; #1;
    check("R1 ien clear, masks set", irq_pend_o, 0);
    ext_req_i = 1'b0; rq_mid_i = 1'b0;
  endtask

  task automatic t_strobe();
    ien_on();
    ext_req_i = 1'b1; #1;
    check("R12 pend without strobe", irq_pend_o, 1);
    for (int i = 0; i < 4; i++) step();
    check("R4 no hold without strobe", pc_hold_o, 0);
    sample();
    check("R6 ack", ext_ack_o, 1);
    check("R4 hold", pc_hold_o, 1);
    check("R6 vec zero", vec_o, 16'h0000);
    ext_req_i = 1'b0;
    step();
    check("R4 hold one cycle", pc_hold_o, 0);
    check("R6 ack one cycle", ext_ack_o, 0);
  endtask

  task automatic t_masks();
    write_cmd(5'b00000);          // qualifier clear: masks stay set
    ien_on();
    rq_lo_i = 1'b1; #1;
    check("R10 no write without qualifier", irq_pend_o, 0);
    write_cmd(5'b01000);          // unmask all
    check("R10 unmasked", irq_pend_o, 1);
    sample();
    check("R7 low vector", vec_o, 16'h002C);
    check("R7 no ack", ext_ack_o, 0);
    check("R5 ien cleared on accept", irq_pend_o, 0);
    write_cmd(5'b01001);          // mask low only
    ien_on();
    check("R10 low masked", irq_pend_o, 0);
    sample();
    check("R10 masked not taken", pc_hold_o, 0);
    rq_lo_i = 1'b0;
    write_cmd(5'b01000);
  endtask

  task automatic t_prio();
    ien_on();
    rq_hi_i = 1'b1; step(); rq_hi_i = 1'b0;
    rq_mid_i = 1'b1; rq_lo_i = 1'b1; ext_req_i = 1'b1;
    sample();
    check("R2 R8 high first from latch", vec_o, 16'h003C);
    ien_on(); sample();
    check("R2 middle next", vec_o, 16'h0034);
    rq_mid_i = 1'b0;
    ien_on(); sample();
    check("R2 low next", vec_o, 16'h002C);
    rq_lo_i = 1'b0;
    ien_on(); sample();
    check("R2 general last ack", ext_ack_o, 1);
    ext_req_i = 1'b0;
    ien_on(); rq_mid_i = 1'b1; step(); rq_mid_i = 1'b0; sample();
    check("R9 level dropped not taken", pc_hold_o, 0);
    ien_off();
  endtask

  task automatic t_nmi();
    write_cmd(5'b01111);
    nmi_i = 1'b1; step();
    check("R3 pend despite masks", irq_pend_o, 1);
    sample();
    check("R3 nmi vector", vec_o, 16'h0024);
    check("R7 nmi no ack", ext_ack_o, 0);
    sample();
    check("R11 held level not retaken", pc_hold_o, 0);
    nmi_i = 1'b0; step();
    nmi_i = 1'b1; step(); nmi_i = 1'b0; step();
    sample();
    check("R11 short pulse ignored", pc_hold_o, 0);
    write_cmd(5'b01000);
    ien_on();
    rq_mid_i = 1'b1; nmi_i = 1'b1; step();
    sample();
    check("R2 nmi over middle", vec_o, 16'h0024);
    check("R3 ien kept", irq_pend_o, 1);
    sample();
    check("R3 middle after nmi", vec_o, 16'h0034);
    rq_mid_i = 1'b0; nmi_i = 1'b0; step();
  endtask

  task automatic t_hi_clear();
    write_cmd(5'b01100);           // mask high
    rq_hi_i = 1'b1; step(); rq_hi_i = 1'b0;
    write_cmd(5'b01000);
    ien_on();
    check("R8 masked edge latched", irq_pend_o, 1);
    ien_off();
    write_cmd(5'b10000);           // discard latch
    ien_on();
    check("R8 latch cleared by command", irq_pend_o, 0);
    sample();
    check("R8 nothing taken", pc_hold_o, 0);
  endtask

  task automatic t_ien_both();
    ien_set_i = 1'b1; ien_clr_i = 1'b1; step();
    ien_set_i = 1'b0; ien_clr_i = 1'b0;
    ext_req_i = 1'b1; #1;
    check("R5 clear wins", irq_pend_o, 0);
    ext_req_i = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    {nmi_i, rq_hi_i, rq_mid_i, rq_lo_i, ext_req_i} = '0;
    {ien_set_i, ien_clr_i, cmd_we_i, smp_stb_i} = '0;
    cmd_i = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    t_reset();
    t_strobe();
    t_masks();
    t_prio();
    t_nmi();
    t_hi_clear();
    t_ien_both();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule